// File: doc/BRIEF.md
# Multilane Block Striper with Lane Markers

This block sits on the transmit path of a multilane physical coding layer. It takes a stream of 66-bit blocks that have already been line-coded and scrambled, and deals them out across a parameterised number of lanes. Each block goes whole to one lane, and the lanes take turns in a fixed rotation. The block never changes the contents of a data block.

At a fixed interval, counted in data blocks per lane, the striper spends one clock placing a marker block on every lane at once. Each marker holds a control sync header and the lane's own number, so a receiver can line up lanes that arrive with different delays and can tell which lane is which. During that clock the input handshake is closed, so the upstream source keeps its block and offers it again. Every lane output is registered: a block accepted on one clock edge appears at its lane after that edge.

Top module: `block_lane_striper`

## Requirements
- R1: While reset is high, every lane_valid bit is 0. In the first clock after reset is released, in_ready is 0 and that clock is a marker clock.
- R2: A data block accepted on a clock edge is presented after that edge on exactly one lane, with all 66 bits unchanged. Bits [65:64] are the sync header, and a header of either 01 or 10 passes through untouched.
- R3: After each marker clock, the first accepted data block goes to lane 0. Each following block goes to the next higher lane, and the lane after NUM_LANES-1 is lane 0.
- R4: In any clock, lane_valid is either all zeros, exactly one bit set (a data block), or all ones (markers).
- R5: In a marker clock, every lane g presents {2'b10, g[7:0], ~g[7:0], 48'h8B4D17E235C9} in the following clock, with its valid bit set.
- R6: After a marker clock, exactly MARKER_PERIOD*NUM_LANES data blocks are accepted before the next marker clock, which follows without waiting for further input.
- R7: A marker clock lasts exactly one clock with in_ready low. A block offered during that clock is not lost: it is accepted in a later clock and lands on lane 0.
- R8: A clock with in_valid low sets no lane_valid bit and does not move the lane rotation or the marker interval.
- R9: The lane count is a parameter. Both 4 and 10 lanes give the order and marker behaviour above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block is offered |
| in_block | input | 66 | Coded block, sync header in [65:64] |
| in_ready | output | 1 | Block is taken this clock when in_valid is also high |
| lane_valid | output | NUM_LANES | Per-lane valid for the registered lane output |
| lane_block | output | NUM_LANES*66 | Lane g block in bits [g*66 +: 66] |

## Verification
The assertions check on every cycle that the valid pattern has a legal shape, that the rotation advances by one lane per accepted block, that each accepted block reaches its lane unchanged, that markers carry the control header and the lane number, and that the number of blocks between markers is exactly the configured count. Some behaviour only the bench scenarios can show. This includes the full marker content at the ports, that a block offered in a marker clock lands on lane 0 in a later clock, that idle gaps leave the order alone, that a reset in mid-stream restarts with markers, and that a 10-lane build behaves the same way as a 4-lane build.

// File: rtl/lstr_pkg.sv
package lstr_pkg;

    localparam int unsigned BLK_W = 66;
    localparam logic [1:0]  HDR_CTRL = 2'b10;
    localparam logic [47:0] MARK_FILL = 48'h8B4D17E235C9;

    typedef logic [BLK_W-1:0] blk_t;

    // What the lane registers do on a given clock
    typedef enum logic [1:0] {
        EMIT_IDLE = 2'd0,
        EMIT_DATA = 2'd1,
        EMIT_MARK = 2'd2
    } emit_e;

    // Marker block for one lane: control header, lane id, inverted id, fill
    function automatic blk_t lane_marker(input int unsigned lane);
        logic [7:0] id;
        id = lane[7:0];
        return {HDR_CTRL, id, ~id, MARK_FILL};
    endfunction

endpackage

// File: rtl/lstr_sequencer.sv
module lstr_sequencer
    import lstr_pkg::*;
#(
    parameter int unsigned NUM_LANES     = 4,
    parameter int unsigned MARKER_PERIOD = 2048,
    localparam int unsigned LW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
    localparam int unsigned RW = $clog2(MARKER_PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    output emit_e         emit,
    output logic [LW-1:0] lane_sel
);

    localparam logic [LW-1:0] LAST_SEL   = LW'(NUM_LANES - 1);
    localparam logic [RW-1:0] LAST_ROUND = RW'(MARKER_PERIOD - 1);

    logic          mark_due;
    logic [LW-1:0] ptr;
    logic [RW-1:0] rounds;

    assign in_ready = !mark_due;
    assign lane_sel = ptr;

    always_comb begin
        if (mark_due)      emit = EMIT_MARK;
        else if (in_valid) emit = EMIT_DATA;
        else               emit = EMIT_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mark_due <= 1'b1;
            ptr      <= '0;
            rounds   <= '0;
        end else if (mark_due) begin
            mark_due <= 1'b0;
            ptr      <= '0;
            rounds   <= '0;
        end else if (in_valid) begin
            if (ptr == LAST_SEL) begin
                ptr <= '0;
                if (rounds == LAST_ROUND) begin
                    rounds   <= '0;
                    mark_due <= 1'b1;
                end else begin
                    rounds <= rounds + 1'b1;
                end
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    assert_rotate_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=>
            (ptr == (($past(ptr) == LAST_SEL) ? '0 : $past(ptr) + 1'b1)));

    assert_reset_mark_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !in_ready);

    assert_mark_at_lane0_R3: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> (ptr == '0));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> ($stable(ptr) && in_ready));

endmodule

// File: rtl/lstr_lane_out.sv
module lstr_lane_out
    import lstr_pkg::*;
#(
    parameter int unsigned LANE_IDX = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  emit_e emit,
    input  logic  sel_hit,
    input  blk_t  data_in,
    output logic  valid,
    output blk_t  block
);

    localparam blk_t MARKER = lane_marker(LANE_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            block <= '0;
        end else begin
            unique case (emit)
                EMIT_MARK: begin
                    valid <= 1'b1;
                    block <= MARKER;
                end
                EMIT_DATA: begin
                    valid <= sel_hit;
                    if (sel_hit) block <= data_in;
                end
                default: valid <= 1'b0;
            endcase
        end
    end

    assert_data_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (emit == EMIT_DATA && sel_hit) |=> (valid && block == $past(data_in)));

    assert_marker_fields_R5: assert property (@(posedge clk) disable iff (rst)
        (emit == EMIT_MARK) |=>
            (valid && block[65:64] == 2'b10 && block[63:56] == 8'(LANE_IDX)
             && block[55:48] == ~8'(LANE_IDX)));

endmodule

// File: rtl/block_lane_striper.sv
module block_lane_striper
    import lstr_pkg::*;
#(
    parameter int unsigned NUM_LANES     = 4,
    parameter int unsigned MARKER_PERIOD = 2048
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [65:0]                in_block,
    output logic                       in_ready,
    output logic [NUM_LANES-1:0]       lane_valid,
    output logic [NUM_LANES*66-1:0]    lane_block
);

    localparam int unsigned LW    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
    localparam int unsigned TOTAL = MARKER_PERIOD * NUM_LANES;
    localparam int unsigned CW    = $clog2(TOTAL + 1);

    emit_e         emit;
    logic [LW-1:0] lane_sel;

    lstr_sequencer #(
        .NUM_LANES     (NUM_LANES),
        .MARKER_PERIOD (MARKER_PERIOD)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .emit     (emit),
        .lane_sel (lane_sel)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        blk_t lane_q;
        lstr_lane_out #(
            .LANE_IDX (g)
        ) lane_i (
            .clk     (clk),
            .rst     (rst),
            .emit    (emit),
            .sel_hit (lane_sel == LW'(g)),
            .data_in (in_block),
            .valid   (lane_valid[g]),
            .block   (lane_q)
        );
        assign lane_block[g*BLK_W +: BLK_W] = lane_q;
    end

    // Interval checker: accepted blocks between marker clocks
    logic [CW-1:0] acc_cnt;
    logic          seen_mark;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_cnt   <= '0;
            seen_mark <= 1'b0;
        end else if (!in_ready) begin
            acc_cnt   <= '0;
            seen_mark <= 1'b1;
        end else if (in_valid) begin
            acc_cnt <= acc_cnt + 1'b1;
        end
    end

    assert_period_R6: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && seen_mark) |-> (acc_cnt == CW'(TOTAL)));

    assert_no_overrun_R6: assert property (@(posedge clk) disable iff (rst)
        acc_cnt <= CW'(TOTAL));

    assert_valid_shape_R4: assert property (@(posedge clk) disable iff (rst)
        (lane_valid == '1) || $onehot0(lane_valid));

    assert_one_lane_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> ($countones(lane_valid) == 1));

    assert_stall_once_R7: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready);

    assert_mark_all_R5: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> (lane_valid == '1));

endmodule

// File: tb/block_lane_striper_tb_top.sv
`timescale 1ns/1ps
module block_lane_striper_tb_top;

    localparam int unsigned NA = 4;
    localparam int unsigned PA = 2;
    localparam int unsigned NB = 10;
    localparam int unsigned PB = 3;

    // Row: [4]=in_valid, [3:2]=expected kind (0 none, 1 data, 2 marker), [1:0]=lane
    localparam int NROWS = 15;
    localparam logic [4:0] VEC_TAB [0:NROWS-1] = '{
        5'b1_10_00, 5'b1_01_00, 5'b1_01_01, 5'b0_00_00, 5'b1_01_10,
        5'b1_01_11, 5'b1_01_00, 5'b1_01_01, 5'b1_01_10, 5'b0_00_00,
        5'b1_01_11, 5'b1_10_00, 5'b1_01_00, 5'b0_00_00, 5'b1_01_01
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              a_rst, a_valid, a_ready;
    logic [65:0]       a_block;
    logic [NA-1:0]     a_lv;
    logic [NA*66-1:0]  a_lb;

    logic              b_rst, b_valid, b_ready;
    logic [65:0]       b_block;
    logic [NB-1:0]     b_lv;
    logic [NB*66-1:0]  b_lb;

    block_lane_striper #(.NUM_LANES(NA), .MARKER_PERIOD(PA)) dut_i (
        .clk(clk), .rst(a_rst), .in_valid(a_valid), .in_block(a_block),
        .in_ready(a_ready), .lane_valid(a_lv), .lane_block(a_lb));

    block_lane_striper #(.NUM_LANES(NB), .MARKER_PERIOD(PB)) dut_ten_i (
        .clk(clk), .rst(b_rst), .in_valid(b_valid), .in_block(b_block),
        .in_ready(b_ready), .lane_valid(b_lv), .lane_block(b_lb));

    int checks = 0;
    int errors = 0;

    function automatic logic [65:0] mkdata(input int unsigned seq);
        logic [1:0] hdr;
        hdr = seq[0] ? 2'b10 : 2'b01;
        return {hdr, 64'hA5A5_0000_0000_0000 ^ {32'(seq * 32'h9E37), ~32'(seq)}};
    endfunction

    function automatic logic [65:0] exp_marker(input int unsigned lane);
        logic [7:0] id;
        id = 8'(lane);
        return {2'b10, id, ~id, 48'h8B4D17E235C9};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_a_marker(input string req);
        check(a_lv == '1, req, 66'(a_lv), 66'({NA{1'b1}}));
        for (int g = 0; g < NA; g++)
            check(a_lb[g*66 +: 66] == exp_marker(g), req,
                  a_lb[g*66 +: 66], exp_marker(g));
    endtask

    task automatic check_a_data(input int lane, input logic [65:0] blk, input string req);
        logic [NA-1:0] ev;
        ev = '0;
        ev[lane] = 1'b1;
        check(a_lv == ev, req, 66'(a_lv), 66'(ev));
        check(a_lb[lane*66 +: 66] == blk, req, a_lb[lane*66 +: 66], blk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seq;
        a_rst = 1'b1; a_valid = 1'b0; a_block = '0;
        b_rst = 1'b1; b_valid = 1'b0; b_block = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(a_lv == '0, "R1 reset lane_valid", 66'(a_lv), 66'd0);
        check(b_lv == '0, "R1 reset lane_valid 10", 66'(b_lv), 66'd0);

        // ---- Table walk, 4 lanes ----
        a_rst = 1'b0;
        seq = 0;
        for (int r = 0; r < NROWS; r++) begin
            logic [4:0] row;
            row = VEC_TAB[r];
            a_valid = row[4];
            a_block = mkdata(seq);
            // R7 / R1: ready low exactly on marker rows
            check(a_ready == (row[3:2] != 2'd2), "R7 in_ready per row",
                  66'(a_ready), 66'(row[3:2] != 2'd2));
            @(posedge clk);
            @(negedge clk);
            case (row[3:2])
                2'd2: check_a_marker("R5 marker row");
                2'd1: begin
                    check_a_data(row[1:0], mkdata(seq), "R3 R2 data row");
                    seq++;
                end
                default: check(a_lv == '0, "R8 idle row", 66'(a_lv), 66'd0);
            endcase
        end

        // ---- Mid-stream reset: R1 restart, R3 lane 0 ----
        a_valid = 1'b0;
        a_rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(a_lv == '0, "R1 reset mid-stream", 66'(a_lv), 66'd0);
        a_rst = 1'b0;
        a_valid = 1'b1;
        a_block = mkdata(100);
        check(a_ready == 1'b0, "R1 ready low after reset", 66'(a_ready), 66'd0);
        @(posedge clk);
        @(negedge clk);
        check_a_marker("R1 marker after reset");
        check(a_ready == 1'b1, "R7 ready back", 66'(a_ready), 66'd1);
        @(posedge clk);
        @(negedge clk);
        check_a_data(0, mkdata(100), "R7 held block to lane 0");
        a_valid = 1'b0;

        // ---- 10 lanes, continuous input, two marker intervals: R9 R6 ----
        b_rst = 1'b0;
        b_valid = 1'b1;
        seq = 0;
        for (int c = 0; c < 2 * (PB * NB + 1) + 1; c++) begin
            int p;
            p = c % (PB * NB + 1);
            b_block = mkdata(seq + 500);
            check(b_ready == (p != 0), "R6 R9 ready 10-lane",
                  66'(b_ready), 66'(p != 0));
            @(posedge clk);
            @(negedge clk);
            if (p == 0) begin
                check(b_lv == '1, "R9 marker all lanes", 66'(b_lv), 66'({NB{1'b1}}));
                for (int g = 0; g < NB; g++)
                    check(b_lb[g*66 +: 66] == exp_marker(g), "R5 R9 marker content",
                          b_lb[g*66 +: 66], exp_marker(g));
            end else begin
                int ln;
                logic [NB-1:0] ev;
                ln = (p - 1) % NB;
                ev = '0;
                ev[ln] = 1'b1;
                check(b_lv == ev, "R3 R9 lane order", 66'(b_lv), 66'(ev));
                check(b_lb[ln*66 +: 66] == mkdata(seq + 500), "R2 R9 block intact",
                      b_lb[ln*66 +: 66], mkdata(seq + 500));
                seq++;
            end
        end
        b_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(b_lv == '0, "R8 idle 10-lane", 66'(b_lv), 66'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule